// File: doc/BRIEF.md
# Store Tail Interlock

This block sits in the operand stage of an in-order pipeline and guards a store resource that stays occupied for a short fixed tail after every ordinary store. When an ordinary store reaches its last data cycle, the block opens a tail window of `TAIL_CYCLES` clocks (two by default). If another ordinary store shows up in the stage while that window is open, the block raises a stall request in the same cycle. The stall holds the stage until the window has drained.

Multi-register block moves use a separate set of resources. They neither open the window nor wait on it. Non-store instructions are never held. A small debug output reports how many stall cycles remain, and a busy flag shows whether the window is open. The reset is asynchronous and active low. Its release passes through a two-stage synchronizer inside the block.

Top module: `store_tail_interlock`

## Requirements
- R1: In a cycle with `op_valid`=1, `op_store`=1, `op_blkmove`=0 and `data_last`=1, the window is armed. `tail_left` then reads 2, then 1, then 0 on the following three clock cycles, provided no new arming occurs.
- R2: While `tail_left` is nonzero, `op_valid`=1 with `op_store`=1 and `op_blkmove`=0 drives `stall_req`=1 in that same cycle, without waiting for a clock edge.
- R3: `tail_left` never exceeds 2. A store held behind one earlier store sees at most 2 consecutive cycles of `stall_req`.
- R4: With `op_blkmove`=1, `stall_req` is 0. Also, with `op_blkmove`=1 the window is not armed: `tail_left` only counts down.
- R5: With `op_valid`=0 or `op_store`=0, `stall_req` is 0.
- R6: An arming cycle that occurs while the window is still open reloads `tail_left` to 2 on the next clock.
- R7: With `tail_left`=0, an ordinary store sees `stall_req`=0.
- R8: While `rst_n` is low, and for the first two rising clock edges after it rises, `tail_left`=0, `tail_busy`=0 and `stall_req`=0. Arming inputs have no effect during that time.
- R9: `tail_busy` is 1 exactly when `tail_left` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An instruction is present in the operand stage |
| op_store | input | 1 | The present instruction writes memory |
| op_blkmove | input | 1 | The present instruction is a multi-register block move |
| data_last | input | 1 | This cycle is the final data cycle of the present store |
| stall_req | output | 1 | Hold the operand stage this cycle |
| tail_busy | output | 1 | Store resource occupied by a tail window |
| tail_left | output | 2 | Stall cycles still remaining (0 to 2) |

## Verification
The bench builds the block with its default `TAIL_CYCLES` of 2, which keeps the window short. Every gap of zero to three idle cycles after an arming store can then be crossed with all sixteen combinations of the four instruction flags. That sweep covers stalls in the middle of the window, the first free cycle after it, block moves and non-stores inside it, and reloads of a window that is still open. Separate sequences measure the total hold seen by a waiting store and the two-edge quiet period after reset release.

// File: rtl/stil_pkg.sv
package stil_pkg;

  typedef struct packed {
    logic valid;
    logic store;
    logic blkmove;
    logic last;
  } stil_op_t;

  function automatic int unsigned stil_cnt_width(input int unsigned tail);
    return (tail < 2) ? 1 : $clog2(tail + 1);
  endfunction

endpackage

// File: rtl/stil_rst_sync.sv
module stil_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stil_classify.sv
module stil_classify
  import stil_pkg::*;
(
  input  stil_op_t op,
  output logic     contend,
  output logic     arm
);

  // Only ordinary stores compete for the shared store resource.
  always_comb begin
    contend = op.valid & op.store & ~op.blkmove;
    arm     = contend & op.last;
  end

endmodule

// File: rtl/stil_window.sv
module stil_window #(
  parameter int unsigned TAIL_CYCLES = 2,
  parameter int unsigned CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  output logic [CNT_W-1:0] left,
  output logic             busy
);

  localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL_CYCLES);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic             left_en;

  always_comb begin
    left_en = arm | (left_q != '0);
    if (arm) begin
      left_d = TAIL_V;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end else begin
      left_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign left = left_q;
  assign busy = (left_q != '0);

endmodule

// File: rtl/stil_stall.sv
module stil_stall (
  input  logic contend,
  input  logic busy,
  output logic stall
);

  always_comb begin
    stall = contend & busy;
  end

endmodule

// File: rtl/store_tail_interlock.sv
module store_tail_interlock #(
  parameter int unsigned TAIL_CYCLES = 2,
  localparam int unsigned CNT_W = stil_pkg::stil_cnt_width(TAIL_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_store,
  input  logic             op_blkmove,
  input  logic             data_last,
  output logic             stall_req,
  output logic             tail_busy,
  output logic [CNT_W-1:0] tail_left
);

  import stil_pkg::*;

  logic     rst_sync_n;
  stil_op_t op;
  logic     contend;
  logic     arm;
  logic     busy;

  always_comb begin
    op.valid   = op_valid;
    op.store   = op_store;
    op.blkmove = op_blkmove;
    op.last    = data_last;
  end

  stil_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stil_classify u_classify (
    .op      (op),
    .contend (contend),
    .arm     (arm)
  );

  stil_window #(
    .TAIL_CYCLES (TAIL_CYCLES),
    .CNT_W       (CNT_W)
  ) u_window (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .arm   (arm),
    .left  (tail_left),
    .busy  (busy)
  );

  stil_stall u_stall (
    .contend (contend),
    .busy    (busy),
    .stall   (stall_req)
  );

  assign tail_busy = busy;

endmodule

// File: rtl/stil_checker.sv
module stil_checker #(
  parameter int unsigned TAIL_CYCLES = 2,
  localparam int unsigned CNT_W = stil_pkg::stil_cnt_width(TAIL_CYCLES)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             op_valid,
  input logic             op_store,
  input logic             op_blkmove,
  input logic             data_last,
  input logic             stall_req,
  input logic             tail_busy,
  input logic [CNT_W-1:0] tail_left
);

  localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL_CYCLES);

  logic ordinary;
  assign ordinary = op_valid & op_store & ~op_blkmove;

  p_arm_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (ordinary && data_last) |=> (tail_left == TAIL_V));

  p_decay_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (!(ordinary && data_last) && tail_left != '0) |=> (tail_left == $past(tail_left) - 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (ordinary && tail_left != '0) |-> stall_req);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    tail_left <= TAIL_V);

  p_blk_free_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    op_blkmove |-> !stall_req);

  p_blk_noarm_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_blkmove && tail_left <= 1) |=> (tail_left == '0));

  p_nonstore_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!op_valid || !op_store) |-> !stall_req);

  p_free_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (tail_left == '0) |-> !stall_req);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    tail_busy == (tail_left != '0));

endmodule

bind store_tail_interlock stil_checker #(.TAIL_CYCLES(TAIL_CYCLES)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .op_valid   (op_valid),
  .op_store   (op_store),
  .op_blkmove (op_blkmove),
  .data_last  (data_last),
  .stall_req  (stall_req),
  .tail_busy  (tail_busy),
  .tail_left  (tail_left)
);

// File: tb/store_tail_interlock_tb.sv
module store_tail_interlock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAIL       = 2;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic       op_store;
  logic       op_blkmove;
  logic       data_last;
  logic       stall_req;
  logic       tail_busy;
  logic [1:0] tail_left;

  int checks;
  int errors;
  bit done;

  store_tail_interlock #(.TAIL_CYCLES(TAIL)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_store   (op_store),
    .op_blkmove (op_blkmove),
    .data_last  (data_last),
    .stall_req  (stall_req),
    .tail_busy  (tail_busy),
    .tail_left  (tail_left)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Apply flags just after a falling edge so they settle well before the next rising edge.
  task automatic put(input logic v, input logic s, input logic b, input logic l);
    @(negedge clk);
    op_valid = v; op_store = s; op_blkmove = b; data_last = l;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    op_valid = 1'b0; op_store = 1'b0; op_blkmove = 1'b0; data_last = 1'b0;

    // R8: reset holds everything quiet even with arming inputs present
    put(1'b1, 1'b1, 1'b0, 1'b1);
    idle(0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R8", "tail_left in reset", int'(tail_left), 0);
    check("R8", "tail_busy in reset", int'(tail_busy), 0);
    check("R8", "stall_req in reset", int'(stall_req), 0);
    rst_n = 1'b1;             // released at a falling edge, arming inputs still held
    @(posedge clk); @(negedge clk); #1;
    check("R8", "tail_left after 1st edge", int'(tail_left), 0);
    @(posedge clk); @(negedge clk); #1;
    check("R8", "tail_left after 2nd edge", int'(tail_left), 0);
    check("R8", "stall_req after 2nd edge", int'(stall_req), 0);
    @(posedge clk); @(negedge clk); #1;
    check("R1", "tail_left arms after sync", int'(tail_left), TAIL);
    idle(4);

    // Sweep: arm, d idle cycles, then every flag combination
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 16; c++) begin
        logic v, s, b, l;
        int   exp_left, exp_stall, exp_next;
        bit   ord;
        v = c[3]; s = c[2]; b = c[1]; l = c[0];
        idle(4);
        put(1'b1, 1'b1, 1'b0, 1'b1);      // arming store
        idle(d);
        put(v, s, b, l);
        exp_left  = (d + 1 <= TAIL) ? TAIL - d : 0;
        ord       = v & s & ~b;
        exp_stall = (ord && exp_left != 0) ? 1 : 0;
        check("R9", "tail_left in window", int'(tail_left), exp_left);
        check("R9", "tail_busy", int'(tail_busy), (exp_left != 0) ? 1 : 0);
        if (v && s && b)        check("R4", "stall_req blkmove", int'(stall_req), exp_stall);
        else if (!v || !s)      check("R5", "stall_req non-store", int'(stall_req), exp_stall);
        else if (exp_left != 0) check("R2", "stall_req busy store", int'(stall_req), exp_stall);
        else                    check("R7", "stall_req free store", int'(stall_req), exp_stall);
        exp_next = (ord && l) ? TAIL : ((exp_left > 0) ? exp_left - 1 : 0);
        @(negedge clk); #1;
        if (ord && l && exp_left != 0) check("R6", "reload while open", int'(tail_left), exp_next);
        else if (b && s && v)          check("R4", "blkmove no arm", int'(tail_left), exp_next);
        else                           check("R1", "tail_left next", int'(tail_left), exp_next);
      end
    end

    // R3: a store held right after an arming store waits exactly TAIL cycles
    begin
      int held;
      idle(4);
      put(1'b1, 1'b1, 1'b0, 1'b1);
      held = 0;
      for (int i = 0; i < 6; i++) begin
        put(1'b1, 1'b1, 1'b0, 1'b0);
        if (stall_req) held++;
        check("R3", "tail_left bound", (tail_left <= TAIL) ? 1 : 0, 1);
      end
      check("R3", "total hold cycles", held, TAIL);
      // held store now completes: window restarts (R6 / R1)
      put(1'b1, 1'b1, 1'b0, 1'b1);
      check("R7", "stall_req after window", int'(stall_req), 0);
      @(negedge clk); #1;
      check("R6", "window restarted", int'(tail_left), TAIL);
    end

    // R4: block-move final cycle on an idle window leaves it closed
    idle(4);
    put(1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); #1;
    check("R4", "blkmove does not arm", int'(tail_left), 0);

    idle(2);
    done = 1'b1;
    report();
  end

endmodule